// File: doc/BRIEF.md
# Piecewise-Linear Logarithm / Antilogarithm Converter

This block moves a normalised fixed-point value between the linear domain and the base-2 log domain, in either direction. The direction is chosen per item by a mode bit. In log mode the input is a signed exponent `e` and an unsigned fraction `m` that together stand for 2^e·(1+m). The result keeps `e` as its integer part and gives an approximation of log2(1+m) as its fraction. In antilog mode the input is a log value with integer part `e` and fraction `f`. The result keeps `e` as the exponent of the linear value and gives an approximation of 2^f − 1 as its mantissa fraction.

Each direction splits its input range into uniform segments and uses one straight-line fit per segment. The slope multiply is replaced by a sum of right-shifted copies of the input; the shift amounts and a signed offset come from a table that is built at elaboration. The shifted copies and the offset pass through a 3:2 carry-save chain and then one carry-propagate adder. The log direction has 15 fits with three shifts each: the top 4 fraction bits choose the fit, and code 15 shares fit 14. The antilog direction has 8 fits with two shifts each, chosen by the top 3 fraction bits. Segment 0 of each direction is anchored at zero, so a zero fraction converts exactly.

Items arrive and leave on valid/ready streams, with one register stage between them. An item is accepted on a clock edge where `in_valid` and `in_ready` are both high, and it is delivered on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low the output is held unchanged and `in_ready` is low, so back-pressure reaches the producer in the same cycle. When the consumer takes the held item, `in_ready` is high in that same cycle, so a new item can move in without a gap.

Top module: `pwl_logconv`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0. In the first cycle after release, `in_ready` is 1.
- R2: An item accepted on one clock edge shows up on the output with `out_valid` high just after the next edge. With `out_ready` held high, items accepted on consecutive edges come out on consecutive edges, in order.
- R3: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, `out_valid` stays 1, and `out_exp` and `out_frac` keep their values.
- R4: `in_ready` is 1 in any cycle where `out_valid` is 0 or `out_ready` is 1.
- R5: In both modes `out_exp` equals the `in_exp` of the same item, as an 8-bit two's-complement value.
- R6: Log mode (`in_dir` = 0): `out_frac`/65536 is within 2^-6 of log2(1 + `in_frac`/65536).
- R7: Antilog mode (`in_dir` = 1): `out_frac`/65536 is within 2^-6 of 2^(`in_frac`/65536) − 1.
- R8: `in_frac` = 0 gives `out_frac` = 0 exactly, in both modes.
- R9: In log mode, fractions whose top 4 bits are 1111 or 1110 share one fit, and R6 holds over that whole top eighth of the range.
- R10: The fraction result is clamped to the range 0 to 0xFFFF and never wraps. `in_frac` = 0xFFFF gives at least 0xFC00 in both modes.
- R11: When the consumer takes the held item and no new item is offered, `out_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Block can take an input item this cycle |
| in_dir | input | 1 | 0 = linear to log, 1 = log to linear |
| in_exp | input | 8 | Exponent or integer part, two's complement |
| in_frac | input | 16 | Mantissa or log fraction, unsigned, weight 2^-16 per LSB |
| out_valid | output | 1 | Output item present |
| out_ready | input | 1 | Consumer takes the output item this cycle |
| out_exp | output | 8 | Exponent or integer part of the result |
| out_frac | output | 16 | Converted fraction, weight 2^-16 per LSB |

## Verification
The hardest state to reach from the ports is a stalled output with a different item already waiting at the input. In that state the held result must not change and the waiting item must not be taken early. The stimulus gets there by holding `out_ready` low after one accepted item and then presenting a second item, with a different exponent and mode, for several cycles. It then raises `out_ready` and checks that the second item moves in on that same edge and drains on the following one. A second hard region is the folded top log segment and the clamp edge at 0xFFFF. Directed points at the start of code 1110, inside code 1111 and at the maximum fraction reach both.

// File: rtl/pwl_conv_pkg.sv
package pwl_conv_pkg;
  localparam int SHW = 5;

  typedef enum logic {
    DIR_LOG  = 1'b0,
    DIR_ALOG = 1'b1
  } conv_dir_e;
endpackage

// File: rtl/pwl_csa.sv
module pwl_csa #(
  parameter int AW = 20
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  input  logic [AW-1:0] c,
  output logic [AW-1:0] s,
  output logic [AW-1:0] cy
);
  logic [AW-1:0] maj;

  assign s   = a ^ b ^ c;
  assign maj = (a & b) | (a & c) | (b & c);
  assign cy  = {maj[AW-2:0], 1'b0};
endmodule

// File: rtl/pwl_seg_rom.sv
module pwl_seg_rom
  import pwl_conv_pkg::*;
#(
  parameter int FW       = 16,
  parameter int SEG_BITS = 4,
  parameter int TERMS    = 3,
  parameter bit FOLD_TOP = 1'b1,
  parameter bit IS_LOG   = 1'b1
) (
  input  logic [SEG_BITS-1:0]  idx,
  output logic [TERMS*SHW-1:0] shifts,
  output logic [FW+3:0]        offset
);
  localparam int    AW   = FW + 4;
  localparam int    NSEG = 1 << SEG_BITS;
  localparam int    NENT = FOLD_TOP ? NSEG - 1 : NSEG;
  localparam longint ONE  = longint'(1) << FW;
  localparam longint STEP = longint'(1) << (FW - SEG_BITS);

  // log2(1 + x/ONE) scaled by ONE, floor, by repeated squaring
  function automatic longint f_log2(input longint x);
    logic [63:0] y;
    longint r;
    if (x >= ONE) return ONE;
    y = 64'(ONE + x) << (30 - FW);
    r = 0;
    for (int i = FW - 1; i >= 0; i--) begin
      y = (y * y) >> 30;
      if (y >= (64'd1 << 31)) begin
        y = y >> 1;
        r = r | (longint'(1) << i);
      end
    end
    return r;
  endfunction

  // 2^(x/ONE) - 1 scaled by ONE, by bisection on f_log2
  function automatic longint f_exp2m1(input longint x);
    longint lo, hi, mid;
    if (x >= ONE) return ONE;
    lo = 0;
    hi = ONE - 1;
    for (int it = 0; it <= FW + 1; it++) begin
      if (lo < hi) begin
        mid = (lo + hi + 1) / 2;
        if (f_log2(mid) <= x) lo = mid;
        else hi = mid - 1;
      end
    end
    return lo;
  endfunction

  function automatic longint fval(input longint x);
    return IS_LOG ? f_log2(x) : f_exp2m1(x);
  endfunction

  function automatic longint seg_len(input int g);
    return (FOLD_TOP && g == NENT - 1) ? 2 * STEP : STEP;
  endfunction

  function automatic longint seg_slope(input int g);
    longint s0, l;
    s0 = longint'(g) * STEP;
    l  = seg_len(g);
    return ((fval(s0 + l) - fval(s0)) * ONE) / l;
  endfunction

  // greedy shifts below the slope, nearest power of two for the last term
  function automatic logic [TERMS*SHW-1:0] pick_shifts(input longint a);
    logic [TERMS*SHW-1:0] res;
    longint r, err, best_err, v;
    int k, best;
    r   = a;
    res = '0;
    for (int t = 0; t < TERMS - 1; t++) begin
      k = 31;
      for (int kk = FW - 1; kk >= 0; kk--)
        if ((ONE >> kk) <= r) k = kk;
      if (k != 31) r = r - (ONE >> k);
      res[t*SHW +: SHW] = SHW'(k);
    end
    best     = 31;
    best_err = r;
    for (int kk = 0; kk < FW; kk++) begin
      v   = ONE >> kk;
      err = (r > v) ? r - v : v - r;
      if (err < best_err) begin
        best_err = err;
        best     = kk;
      end
    end
    res[(TERMS-1)*SHW +: SHW] = SHW'(best);
    return res;
  endfunction

  function automatic longint shift_total(input longint p, input logic [TERMS*SHW-1:0] sh);
    longint acc;
    acc = 0;
    for (int t = 0; t < TERMS; t++)
      acc = acc + (p >> sh[t*SHW +: SHW]);
    return acc;
  endfunction

  // segment 0 anchored at zero, the rest at their midpoint
  function automatic longint seg_offset(input int g);
    longint p;
    p = (g == 0) ? 0 : longint'(g) * STEP + seg_len(g) / 2;
    return fval(p) - shift_total(p, pick_shifts(seg_slope(g)));
  endfunction

  logic [TERMS*SHW-1:0] sh_tbl  [NENT];
  logic [AW-1:0]        off_tbl [NENT];
  logic [SEG_BITS-1:0]  idx_eff;

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    localparam logic [TERMS*SHW-1:0] SH  = pick_shifts(seg_slope(g));
    localparam longint               OFF = seg_offset(g);
    assign sh_tbl[g]  = SH;
    assign off_tbl[g] = AW'(OFF);
  end

  if (FOLD_TOP) begin : g_fold
    assign idx_eff = (idx == SEG_BITS'(NSEG - 1)) ? SEG_BITS'(NSEG - 2) : idx;
  end else begin : g_nofold
    assign idx_eff = idx;
  end

  assign shifts = sh_tbl[idx_eff];
  assign offset = off_tbl[idx_eff];
endmodule

// File: rtl/pwl_shift_sum.sv
module pwl_shift_sum
  import pwl_conv_pkg::*;
#(
  parameter int FW    = 16,
  parameter int TERMS = 3
) (
  input  logic [FW-1:0]        x,
  input  logic [TERMS*SHW-1:0] shifts,
  input  logic [FW+3:0]        offset,
  output logic [FW+3:0]        sum
);
  localparam int AW   = FW + 4;
  localparam int NOPS = TERMS + 1;
  localparam int NCSA = TERMS - 1;

  logic [AW-1:0] ops  [NOPS];
  logic [AW-1:0] s_ch [NCSA+1];
  logic [AW-1:0] c_ch [NCSA+1];

  for (genvar t = 0; t < TERMS; t++) begin : g_op
    assign ops[t] = AW'(x >> shifts[t*SHW +: SHW]);
  end
  assign ops[TERMS] = offset;

  assign s_ch[0] = ops[0];
  assign c_ch[0] = ops[1];

  for (genvar j = 0; j < NCSA; j++) begin : g_csa
    pwl_csa #(.AW(AW)) u_csa (
      .a  (s_ch[j]),
      .b  (c_ch[j]),
      .c  (ops[j+2]),
      .s  (s_ch[j+1]),
      .cy (c_ch[j+1])
    );
  end

  assign sum = s_ch[NCSA] + c_ch[NCSA];
endmodule

// File: rtl/pwl_logconv.sv
module pwl_logconv
  import pwl_conv_pkg::*;
#(
  parameter int FW        = 16,
  parameter int EW        = 8,
  parameter int LSEG_BITS = 4,
  parameter int ASEG_BITS = 3,
  parameter int LTERMS    = 3,
  parameter int ATERMS    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_dir,
  input  logic [EW-1:0] in_exp,
  input  logic [FW-1:0] in_frac,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [EW-1:0] out_exp,
  output logic [FW-1:0] out_frac
);
  localparam int AW = FW + 4;

  conv_dir_e               dir;
  logic [LSEG_BITS-1:0]    l_idx;
  logic [ASEG_BITS-1:0]    a_idx;
  logic [LTERMS*SHW-1:0]   l_sh;
  logic [ATERMS*SHW-1:0]   a_sh;
  logic [AW-1:0]           l_off, a_off, l_sum, a_sum, pick;
  logic [FW-1:0]           res;

  assign dir   = conv_dir_e'(in_dir);
  assign l_idx = in_frac[FW-1 -: LSEG_BITS];
  assign a_idx = in_frac[FW-1 -: ASEG_BITS];

  pwl_seg_rom #(
    .FW(FW), .SEG_BITS(LSEG_BITS), .TERMS(LTERMS), .FOLD_TOP(1'b1), .IS_LOG(1'b1)
  ) u_log_rom (
    .idx(l_idx), .shifts(l_sh), .offset(l_off)
  );

  pwl_shift_sum #(.FW(FW), .TERMS(LTERMS)) u_log_sum (
    .x(in_frac), .shifts(l_sh), .offset(l_off), .sum(l_sum)
  );

  pwl_seg_rom #(
    .FW(FW), .SEG_BITS(ASEG_BITS), .TERMS(ATERMS), .FOLD_TOP(1'b0), .IS_LOG(1'b0)
  ) u_alog_rom (
    .idx(a_idx), .shifts(a_sh), .offset(a_off)
  );

  pwl_shift_sum #(.FW(FW), .TERMS(ATERMS)) u_alog_sum (
    .x(in_frac), .shifts(a_sh), .offset(a_off), .sum(a_sum)
  );

  always_comb begin
    pick = (dir == DIR_LOG) ? l_sum : a_sum;
    if (pick[AW-1])            res = '0;
    else if (|pick[AW-2:FW])   res = '1;
    else                       res = pick[FW-1:0];
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_exp   <= '0;
      out_frac  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (in_valid && in_ready) begin
        out_exp  <= in_exp;
        out_frac <= res;
      end
    end
  end
endmodule

// File: rtl/pwl_logconv_chk.sv
module pwl_logconv_chk #(
  parameter int FW = 16,
  parameter int EW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_dir,
  input logic [EW-1:0] in_exp,
  input logic [FW-1:0] in_frac,
  input logic          out_valid,
  input logic          out_ready,
  input logic [EW-1:0] out_exp,
  input logic [FW-1:0] out_frac
);
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R2

  AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_exp) && $stable(out_frac)); // R3

  AST_STALL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R3

  AST_FREE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid || out_ready |-> in_ready); // R4

  AST_EXP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_exp == $past(in_exp)); // R5

  AST_ZERO_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_frac == '0 |=> out_frac == '0); // R8

  AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid); // R11
endmodule

bind pwl_logconv pwl_logconv_chk #(.FW(FW), .EW(EW)) u_pwl_logconv_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_dir(in_dir), .in_exp(in_exp), .in_frac(in_frac), .out_valid(out_valid),
  .out_ready(out_ready), .out_exp(out_exp), .out_frac(out_frac)
);

// File: tb/test_pwl_logconv.sv
`timescale 1ns/1ps
module test_pwl_logconv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_dir = 1'b0;
  logic [7:0]  in_exp = '0;
  logic [15:0] in_frac = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_exp;
  logic [15:0] out_frac;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwl_logconv i_pwl_logconv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dir(in_dir), .in_exp(in_exp), .in_frac(in_frac), .out_valid(out_valid),
    .out_ready(out_ready), .out_exp(out_exp), .out_frac(out_frac)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic real ref_val(input logic d, input logic [15:0] f);
    real x;
    x = f / 65536.0;
    return d ? (2.0 ** x) - 1.0 : $ln(1.0 + x) / $ln(2.0);
  endfunction

  task automatic xfer(input logic d, input logic [7:0] e, input logic [15:0] f,
                      output logic ok, output logic [7:0] ge, output logic [15:0] gf);
    @(negedge clk);
    in_valid = 1'b1; in_dir = d; in_exp = e; in_frac = f; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    ok = out_valid; ge = out_exp; gf = out_frac;
  endtask

  task automatic check_point(input string req, input logic d, input logic [15:0] f);
    logic ok; logic [7:0] ge; logic [15:0] gf; real r, err;
    xfer(d, 8'h11, f, ok, ge, gf);
    r   = ref_val(d, f);
    err = (gf / 65536.0) - r;
    if (err < 0.0) err = -err;
    chk(ok && err <= 1.0 / 64.0, req, $sformatf("dir=%0d frac=%h", d, f),
        gf, longint'(r * 65536.0));
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
  endtask

  task automatic t_log_sweep;
    for (int i = 0; i < 256; i++) check_point("R6", 1'b0, 16'(i * 256 + 37));
  endtask

  task automatic t_alog_sweep;
    for (int i = 0; i < 256; i++) check_point("R7", 1'b1, 16'(i * 256 + 91));
  endtask

  task automatic t_exact_zero;
    logic ok; logic [7:0] ge; logic [15:0] gf;
    xfer(1'b0, 8'h03, 16'h0000, ok, ge, gf);
    chk(ok && gf == 16'h0000, "R8", "log of 1.0", gf, 0);
    xfer(1'b1, 8'hFE, 16'h0000, ok, ge, gf);
    chk(ok && gf == 16'h0000, "R8", "antilog of 0", gf, 0);
  endtask

  task automatic t_top_segment;
    check_point("R9", 1'b0, 16'hE000);
    check_point("R9", 1'b0, 16'hEFFF);
    check_point("R9", 1'b0, 16'hF000);
    check_point("R9", 1'b0, 16'hF800);
    check_point("R9", 1'b0, 16'hFFF0);
  endtask

  task automatic t_clamp;
    logic ok; logic [7:0] ge; logic [15:0] gf;
    xfer(1'b0, 8'h00, 16'hFFFF, ok, ge, gf);
    chk(ok && gf >= 16'hFC00, "R10", "log at max fraction", gf, 16'hFC00);
    xfer(1'b1, 8'h00, 16'hFFFF, ok, ge, gf);
    chk(ok && gf >= 16'hFC00, "R10", "antilog at max fraction", gf, 16'hFC00);
  endtask

  task automatic t_exponent;
    logic ok; logic [7:0] ge; logic [15:0] gf;
    xfer(1'b0, 8'h80, 16'h4000, ok, ge, gf);
    chk(ok && ge == 8'h80, "R5", "log exp -128", ge, 8'h80);
    xfer(1'b1, 8'h7F, 16'h4000, ok, ge, gf);
    chk(ok && ge == 8'h7F, "R5", "antilog exp 127", ge, 8'h7F);
    xfer(1'b1, 8'hFF, 16'hA000, ok, ge, gf);
    chk(ok && ge == 8'hFF, "R5", "antilog exp -1", ge, 8'hFF);
  endtask

  task automatic t_stream;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk(out_valid == 1'b1, "R2", "stream valid", out_valid, 1);
        chk(out_exp == 8'(i + 39) && out_frac == 16'h0000, "R2", "stream order",
            out_exp, i + 39);
      end
      chk(in_ready == 1'b1, "R4", "stream ready", in_ready, 1);
      in_valid = 1'b1; in_dir = 1'(i); in_exp = 8'(i + 40); in_frac = 16'h0000;
      out_ready = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_exp == 8'd47, "R2", "stream last", out_exp, 47);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    in_valid = 1'b1; in_dir = 1'b0; in_exp = 8'h05; in_frac = 16'h0000; out_ready = 1'b0;
    @(negedge clk);
    in_dir = 1'b1; in_exp = 8'hFD; in_frac = 16'h0000;
    for (int k = 0; k < 3; k++) begin
      chk(out_valid == 1'b1, "R3", "held valid", out_valid, 1);
      chk(in_ready == 1'b0, "R3", "ready low in stall", in_ready, 0);
      chk(out_exp == 8'h05 && out_frac == 16'h0000, "R3", "held data", out_exp, 5);
      @(negedge clk);
    end
    out_ready = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R4", "ready on consume", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_exp == 8'hFD && out_frac == 16'h0000, "R3", "waiting item moved",
        out_exp, 8'hFD);
    @(negedge clk);
    chk(out_valid == 1'b0, "R11", "drained", out_valid, 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_exact_zero();
    t_exponent();
    t_log_sweep();
    t_alog_sweep();
    t_top_segment();
    t_clamp();
    t_stream();
    t_backpressure();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule